// File: doc/BRIEF.md
# Colour Space Conversion Pipeline

This block converts a stream of three-component pixels from one colour space to another inside a display pipe. Each component is limited to a configurable window, offset by a signed bias and fed through a 3x3 signed fixed-point matrix. The matrix result is rounded, offset again by a second bias and saturated into a second window before it leaves the block. Pixels arrive and leave on a valid/ready handshake, and a stalled output holds the whole pipeline.

All coefficients, biases, limits and mode bits are written through a simple word-write port into a staging copy. A one-cycle frame-start strobe moves the staging copy into the working copy, so software can reprogram the block at any time without disturbing the frame in flight. When conversion is disabled, pixels pass through untouched. Two mode bits mark the input and output as YUV or RGB, and the output carries a matching format flag.

Top module: `csc_pipe`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and the working configuration has conversion disabled, all coefficients and biases zero and every limit window set to [0,255].
- R2: The configuration map is as follows. Word 0 holds the mode: bit 0 enables conversion, bit 1 marks the source as YUV and bit 2 marks the destination as YUV. Words 1 to 5 hold the nine 13-bit coefficients k0..k8 in row-major order (k[3r+c] weights input component c into output component r). Word 1+j carries k[2j] in bits [12:0] and k[2j+1] in bits [28:16], and word 5 carries only k8. Words 6-8 are the pre-clamp windows and words 9-11 the post-clamp windows of components 0-2, each with its low limit in bits [7:0] and its high limit in bits [15:8]. Words 12-14 are the pre-biases and words 15-17 the post-biases of components 0-2, each a signed value in bits [8:0].
- R3: A write changes only the staging copy. The working copy takes the staging copy only on a clock edge where `frame_start` is 1; a write on that same edge lands in the next frame.
- R4: With conversion disabled, `out_pix` equals the accepted `in_pix` bit for bit.
- R5: With conversion enabled, each input component is first limited to its pre-clamp window. Its signed pre-bias is then added. If a window's low limit exceeds its high limit, the high limit wins.
- R6: Each matrix output is the sum over c of k[3r+c]·b[c], with coefficients holding 9 fractional bits (512 = 1.0). The sum is rounded to nearest by adding 256 and then shifted arithmetically right by 9.
- R7: The post-bias is added to each matrix output, and the result is saturated into that component's post-clamp window, with the high limit winning. This applies to results both above 255 and below 0.
- R8: A pixel accepted on clock edge n with `out_ready` held at 1 is presented so that its output handshake completes on edge n+3. Pixels leave in acceptance order.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_pix` and `out_yuv` stay unchanged. No pixel is lost or duplicated under any `out_ready` pattern.
- R10: `out_yuv` equals the destination-YUV bit when conversion is enabled and the source-YUV bit when it is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_addr | input | 5 | Configuration word index |
| cfg_wdata | input | 32 | Configuration word data |
| frame_start | input | 1 | Moves the staging configuration into the working configuration |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high together with in_valid |
| in_pix | input | 24 | Input pixel, component c in bits [8c+7:8c] |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream can take the output pixel |
| out_pix | output | 24 | Output pixel, same component layout as the input |
| out_yuv | output | 1 | Output pixel is tagged as YUV |

## Verification
Two situations are the hardest to reach from the ports. The first is a staging configuration that differs from the working one, so a write visibly has no effect until the frame strobe. The bench programs a component-swapping matrix, pushes a pixel before and after the strobe, and expects the first to pass through unchanged. The second is a full pipeline frozen by a stalled output while new pixels keep arriving. A long run with random gaps on both handshakes covers it, and a reference model checks every output and the held value during each stall. An inverted pre-clamp window and matrix results both above 255 and below zero exercise the saturation paths.

// File: rtl/csc_pkg.sv
`timescale 1ns/1ps
package csc_pkg;
    parameter int CW   = 8;    // component width
    parameter int NC   = 3;    // components per pixel
    parameter int KW   = 13;   // coefficient width
    parameter int FRAC = 9;    // coefficient fractional bits
    parameter int BW   = 9;    // bias width
    parameter int AW   = 5;    // configuration address width
    parameter int DW   = 32;   // configuration data width
    parameter int LANE = 16;   // bit offset of the second coefficient in a word

    localparam int NK  = NC * NC;
    localparam int PW  = CW + 2;          // biased sample width
    localparam int MW  = 16;              // matrix output width
    localparam int ACW = KW + PW + 3;     // accumulator width
    localparam int PXW = NC * CW;

    localparam logic [AW-1:0] A_MODE   = AW'(0);
    localparam logic [AW-1:0] A_COEF   = AW'(1);
    localparam logic [AW-1:0] A_PRECL  = AW'(6);
    localparam logic [AW-1:0] A_POSTCL = AW'(9);
    localparam logic [AW-1:0] A_PREB   = AW'(12);
    localparam logic [AW-1:0] A_POSTB  = AW'(15);

    typedef logic [CW-1:0]        comp_t;
    typedef logic signed [KW-1:0] coef_t;
    typedef logic signed [BW-1:0] bias_t;
    typedef logic signed [PW-1:0] smp_t;
    typedef logic signed [MW-1:0] wide_t;

    typedef struct packed {
        comp_t hi;
        comp_t lo;
    } lim_t;

    typedef struct packed {
        logic                en;
        logic                src_yuv;
        logic                dst_yuv;
        coef_t [NK-1:0]      k;
        bias_t [NC-1:0]      pre_b;
        bias_t [NC-1:0]      post_b;
        lim_t  [NC-1:0]      pre_l;
        lim_t  [NC-1:0]      post_l;
    } cfg_t;

    function automatic cfg_t cfg_default();
        cfg_t c;
        c = '0;
        for (int i = 0; i < NC; i++) begin
            c.pre_l[i].hi  = '1;
            c.post_l[i].hi = '1;
        end
        return c;
    endfunction

    // saturate into [lo,hi]; the high limit is applied last and wins
    function automatic comp_t clamp(input wide_t v, input lim_t l);
        wide_t r;
        r = v;
        if (r < $signed(MW'(l.lo))) r = $signed(MW'(l.lo));
        if (r > $signed(MW'(l.hi))) r = $signed(MW'(l.hi));
        return r[CW-1:0];
    endfunction
endpackage

// File: rtl/csc_cfg_regs.sv
`timescale 1ns/1ps
module csc_cfg_regs import csc_pkg::*; (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          frame_start,
    output cfg_t          act
);
    cfg_t stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= cfg_default();
            act <= cfg_default();
        end else begin
            if (frame_start) act <= stg;
            if (wr_en) begin
                if (wr_addr == A_MODE) begin
                    stg.en      <= wr_data[0];
                    stg.src_yuv <= wr_data[1];
                    stg.dst_yuv <= wr_data[2];
                end
                for (int n = 0; n < NK; n++) begin
                    if (wr_addr == AW'(int'(A_COEF) + n / 2)) begin
                        if (n % 2 == 0) stg.k[n] <= wr_data[KW-1:0];
                        else            stg.k[n] <= wr_data[LANE+KW-1:LANE];
                    end
                end
                for (int i = 0; i < NC; i++) begin
                    if (wr_addr == AW'(int'(A_PRECL) + i))  stg.pre_l[i]  <= wr_data[2*CW-1:0];
                    if (wr_addr == AW'(int'(A_POSTCL) + i)) stg.post_l[i] <= wr_data[2*CW-1:0];
                    if (wr_addr == AW'(int'(A_PREB) + i))   stg.pre_b[i]  <= wr_data[BW-1:0];
                    if (wr_addr == AW'(int'(A_POSTB) + i))  stg.post_b[i] <= wr_data[BW-1:0];
                end
            end
        end
    end

    // working copy moves only on the frame strobe
    assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(act));
endmodule

// File: rtl/csc_pre_stage.sv
`timescale 1ns/1ps
module csc_pre_stage import csc_pkg::*; (
    input  logic            clk,
    input  logic            rst,
    input  logic            adv,
    input  logic            vin,
    input  logic [PXW-1:0]  pix,
    input  cfg_t            cfg,
    output logic            vout,
    output logic            en,
    output logic            tag,
    output logic [PXW-1:0]  raw,
    output smp_t [NC-1:0]   smp
);
    smp_t [NC-1:0] smp_d;

    always_comb begin
        for (int c = 0; c < NC; c++) begin
            smp_d[c] = $signed({2'b00, clamp(wide_t'(pix[c*CW +: CW]), cfg.pre_l[c])})
                     + smp_t'($signed(cfg.pre_b[c]));
        end
    end

    always_ff @(posedge clk) begin
        if (rst)      vout <= 1'b0;
        else if (adv) vout <= vin;
    end

    always_ff @(posedge clk) begin
        if (adv) begin
            en  <= cfg.en;
            tag <= cfg.en ? cfg.dst_yuv : cfg.src_yuv;
            raw <= pix;
            smp <= smp_d;
        end
    end
endmodule

// File: rtl/csc_mat_stage.sv
`timescale 1ns/1ps
module csc_mat_stage import csc_pkg::*; (
    input  logic            clk,
    input  logic            rst,
    input  logic            adv,
    input  logic            vin,
    input  logic            en_in,
    input  logic            tag_in,
    input  logic [PXW-1:0]  raw_in,
    input  smp_t [NC-1:0]   smp,
    input  cfg_t            cfg,
    output logic            vout,
    output logic            en,
    output logic            tag,
    output logic [PXW-1:0]  raw,
    output wide_t [NC-1:0]  mat
);
    wide_t [NC-1:0] mat_d;

    for (genvar r = 0; r < NC; r++) begin : g_row
        logic signed [ACW-1:0] acc;
        always_comb begin
            acc = ACW'(1 << (FRAC - 1));
            for (int c = 0; c < NC; c++) begin
                acc = acc + ACW'($signed(cfg.k[r*NC+c])) * ACW'($signed(smp[c]));
            end
        end
        assign mat_d[r] = wide_t'(acc >>> FRAC);
    end

    always_ff @(posedge clk) begin
        if (rst)      vout <= 1'b0;
        else if (adv) vout <= vin;
    end

    always_ff @(posedge clk) begin
        if (adv) begin
            en  <= en_in;
            tag <= tag_in;
            raw <= raw_in;
            mat <= mat_d;
        end
    end
endmodule

// File: rtl/csc_post_stage.sv
`timescale 1ns/1ps
module csc_post_stage import csc_pkg::*; (
    input  logic            clk,
    input  logic            rst,
    input  logic            adv,
    input  logic            vin,
    input  logic            en_in,
    input  logic            tag_in,
    input  logic [PXW-1:0]  raw_in,
    input  wide_t [NC-1:0]  mat,
    input  cfg_t            cfg,
    output logic            vout,
    output logic            tag,
    output logic [PXW-1:0]  pix
);
    logic [PXW-1:0] pix_d;

    always_comb begin
        for (int c = 0; c < NC; c++) begin
            pix_d[c*CW +: CW] = en_in
                ? clamp($signed(mat[c]) + wide_t'($signed(cfg.post_b[c])), cfg.post_l[c])
                : raw_in[c*CW +: CW];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)      vout <= 1'b0;
        else if (adv) vout <= vin;
    end

    always_ff @(posedge clk) begin
        if (adv) begin
            tag <= tag_in;
            pix <= pix_d;
        end
    end

    // converted output lies inside the post-clamp window in force when it was computed
    for (genvar c = 0; c < NC; c++) begin : g_chk
        assert_post_window_R7: assert property (@(posedge clk) disable iff (rst)
            ($past(adv) && $past(vin) && $past(en_in)
             && ($past(cfg.post_l[c].lo) <= $past(cfg.post_l[c].hi)))
            |-> (pix[c*CW +: CW] >= $past(cfg.post_l[c].lo))
             && (pix[c*CW +: CW] <= $past(cfg.post_l[c].hi)));
    end
endmodule

// File: rtl/csc_pipe.sv
`timescale 1ns/1ps
module csc_pipe import csc_pkg::*; (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  logic [AW-1:0]   cfg_addr,
    input  logic [DW-1:0]   cfg_wdata,
    input  logic            frame_start,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [PXW-1:0]  in_pix,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [PXW-1:0]  out_pix,
    output logic            out_yuv
);
    cfg_t           cfg;
    logic           adv;
    logic           v1, en1, tag1, v2, en2, tag2, v3;
    logic [PXW-1:0] raw1, raw2;
    smp_t  [NC-1:0] smp1;
    wide_t [NC-1:0] mat2;

    // one shared advance: every stage moves unless the last one is stuck
    assign adv       = !v3 || out_ready;
    assign in_ready  = adv;
    assign out_valid = v3;

    csc_cfg_regs u_cfg (
        .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_addr(cfg_addr),
        .wr_data(cfg_wdata), .frame_start(frame_start), .act(cfg)
    );

    csc_pre_stage u_pre (
        .clk(clk), .rst(rst), .adv(adv), .vin(in_valid), .pix(in_pix), .cfg(cfg),
        .vout(v1), .en(en1), .tag(tag1), .raw(raw1), .smp(smp1)
    );

    csc_mat_stage u_mat (
        .clk(clk), .rst(rst), .adv(adv), .vin(v1), .en_in(en1), .tag_in(tag1),
        .raw_in(raw1), .smp(smp1), .cfg(cfg),
        .vout(v2), .en(en2), .tag(tag2), .raw(raw2), .mat(mat2)
    );

    csc_post_stage u_post (
        .clk(clk), .rst(rst), .adv(adv), .vin(v2), .en_in(en2), .tag_in(tag2),
        .raw_in(raw2), .mat(mat2), .cfg(cfg),
        .vout(v3), .tag(out_yuv), .pix(out_pix)
    );

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid && $stable(out_pix) && $stable(out_yuv));

    assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid && in_ready);
endmodule

// File: tb/csc_pipe_tb.sv
`timescale 1ns/1ps
module csc_pipe_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        frame_start = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [23:0] in_pix = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [23:0] out_pix;
    logic        out_yuv;

    always #10 clk = ~clk;

    csc_pipe dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .frame_start(frame_start), .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
        .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix), .out_yuv(out_yuv)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    string cur_req = "R1";
    bit lat_mode = 0;

    // staged (s_) and working (a_) model configuration
    int s_k[9], s_preb[3], s_postb[3], s_plo[3], s_phi[3], s_qlo[3], s_qhi[3];
    int a_k[9], a_preb[3], a_postb[3], a_plo[3], a_phi[3], a_qlo[3], a_qhi[3];
    bit s_en, s_sy, s_dy, a_en, a_sy, a_dy;

    logic [24:0] expq[$];
    int          accq[$];
    bit          prev_stall = 0;
    logic [23:0] hold_pix;
    logic        hold_tag;

    function automatic logic [24:0] model(input logic [23:0] p);
        int b[3];
        int v;
        logic [23:0] o;
        if (!a_en) return {a_sy, p};
        for (int c = 0; c < 3; c++) begin
            v = int'(p[c*8 +: 8]);
            if (v < a_plo[c]) v = a_plo[c];
            if (v > a_phi[c]) v = a_phi[c];
            b[c] = v + a_preb[c];
        end
        for (int r = 0; r < 3; r++) begin
            v = 256;
            for (int c = 0; c < 3; c++) v += a_k[r*3+c] * b[c];
            v = v >>> 9;
            v += a_postb[r];
            if (v < a_qlo[r]) v = a_qlo[r];
            if (v > a_qhi[r]) v = a_qhi[r];
            o[r*8 +: 8] = 8'(v);
        end
        return {a_dy, o};
    endfunction

    task automatic report(input string req, input logic [31:0] act, input logic [31:0] exp_v, input bit ok);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp_v);
        end
    endtask

    // monitor: samples just before each rising edge, when all inputs are settled
    always @(negedge clk) begin
        #8;
        if (!rst) begin
            logic [24:0] e;
            int a;
            cyc++;
            if (prev_stall)
                report("R9", {7'd0, out_valid, out_pix}, {7'd0, 1'b1, hold_pix},
                       out_valid && out_pix == hold_pix && out_yuv == hold_tag);
            prev_stall = out_valid && !out_ready;
            hold_pix   = out_pix;
            hold_tag   = out_yuv;
            if (out_valid && out_ready) begin
                if (expq.size() == 0) begin
                    report("R9", {7'd0, out_yuv, out_pix}, 32'hdead, 1'b0);
                end else begin
                    e = expq.pop_front();
                    a = accq.pop_front();
                    report(cur_req, {7'd0, out_yuv, out_pix}, {7'd0, e}, {out_yuv, out_pix} == e);
                    if (lat_mode) report("R8", 32'(cyc - a), 32'd3, (cyc - a) == 3);
                end
            end
            if (in_valid && in_ready) begin
                expq.push_back(model(in_pix));
                accq.push_back(cyc);
            end
        end
    end

    task automatic wr(input int addr, input logic [31:0] d);
        @(negedge clk); #1;
        cfg_we = 1'b1; cfg_addr = 5'(addr); cfg_wdata = d;
        @(negedge clk); #1;
        cfg_we = 1'b0;
    endtask

    // write the whole staged model into the block using the word map of R2
    task automatic apply_cfg();
        logic [31:0] w;
        wr(0, {29'd0, s_dy, s_sy, s_en});
        for (int j = 0; j < 5; j++) begin
            w = '0;
            w[12:0] = 13'(s_k[2*j]);
            if (j < 4) w[28:16] = 13'(s_k[2*j+1]);
            wr(1 + j, w);
        end
        for (int i = 0; i < 3; i++) begin
            wr(6 + i,  {16'd0, 8'(s_phi[i]), 8'(s_plo[i])});
            wr(9 + i,  {16'd0, 8'(s_qhi[i]), 8'(s_qlo[i])});
            wr(12 + i, {23'd0, 9'(s_preb[i])});
            wr(15 + i, {23'd0, 9'(s_postb[i])});
        end
    endtask

    task automatic send(input logic [23:0] p);
        @(negedge clk); #1;
        in_valid = 1'b1; in_pix = p;
        #8;
        while (!in_ready) begin @(negedge clk); #9; end
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic drain();
        idle();
        while (expq.size() != 0 || out_valid) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic frame();
        drain();
        @(negedge clk); #1; frame_start = 1'b1;
        @(negedge clk); #1; frame_start = 1'b0;
        a_k = s_k; a_preb = s_preb; a_postb = s_postb;
        a_plo = s_plo; a_phi = s_phi; a_qlo = s_qlo; a_qhi = s_qhi;
        a_en = s_en; a_sy = s_sy; a_dy = s_dy;
    endtask

    task automatic base_cfg();
        for (int i = 0; i < 9; i++) s_k[i] = 0;
        for (int i = 0; i < 3; i++) begin
            s_preb[i] = 0; s_postb[i] = 0;
            s_plo[i] = 0; s_phi[i] = 255; s_qlo[i] = 0; s_qhi[i] = 255;
        end
        s_en = 0; s_sy = 0; s_dy = 0;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R9: watchdog expired, actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        base_cfg();
        a_k = s_k; a_preb = s_preb; a_postb = s_postb;
        a_plo = s_plo; a_phi = s_phi; a_qlo = s_qlo; a_qhi = s_qhi;
        a_en = 0; a_sy = 0; a_dy = 0;
        repeat (5) @(negedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        @(negedge clk); #8;
        report("R1", {30'd0, out_valid, in_ready}, 32'd1, !out_valid && in_ready);

        // R4: default configuration passes pixels untouched
        cur_req = "R4";
        send(24'h123456); send(24'hffffff); send(24'h000000); send(24'h80017f);
        drain();

        // R3 and R2: staged swap matrix has no effect until the frame strobe
        base_cfg();
        s_k[2] = 512; s_k[4] = 512; s_k[6] = 512; s_en = 1;
        apply_cfg();
        cur_req = "R3";
        send(24'h112233); send(24'h0a0b0c);
        drain();
        frame();
        cur_req = "R2";
        send(24'h112233); send(24'h0a0b0c); send(24'hff0080);
        drain();

        // R5: pre-clamp then pre-bias, inverted window on component 2
        base_cfg();
        s_k[0] = 512; s_k[4] = 512; s_k[8] = 512; s_en = 1;
        s_plo[0] = 16; s_phi[0] = 235; s_preb[0] = 10;
        s_plo[1] = 16; s_phi[1] = 235; s_preb[1] = -30;
        s_plo[2] = 200; s_phi[2] = 100;
        apply_cfg(); frame();
        cur_req = "R5";
        send(24'h000000); send(24'hffffff); send(24'h808080); send(24'h05eb10); send(24'hc81064);
        drain();

        // R6: BT.601 YUV to RGB with rounding
        base_cfg();
        s_en = 1; s_sy = 1; s_dy = 0;
        s_k[0] = 596; s_k[1] = 0;    s_k[2] = 817;
        s_k[3] = 596; s_k[4] = -200; s_k[5] = -416;
        s_k[6] = 596; s_k[7] = 1033; s_k[8] = 0;
        s_preb[0] = -16; s_preb[1] = -128; s_preb[2] = -128;
        apply_cfg(); frame();
        cur_req = "R6";
        send(24'h808010); send(24'h8080eb); send(24'hf05a51); send(24'h22364f); send(24'h6ed229);
        send(24'h0000ff); send(24'hffff00);
        drain();

        // R8: latency with out_ready held high
        cur_req = "R8";
        lat_mode = 1;
        send(24'h4080c0);
        drain();
        send(24'h204060); send(24'h605040);
        drain();
        lat_mode = 0;

        // R7: post-bias and saturation both ways
        base_cfg();
        s_en = 1;
        s_k[0] = 1024; s_k[4] = -512; s_k[8] = 512;
        s_postb[0] = 100; s_postb[1] = -100;
        s_qlo[2] = 20; s_qhi[2] = 220;
        apply_cfg(); frame();
        cur_req = "R7";
        send(24'h000000); send(24'hffffff); send(24'h0a003c); send(24'hf00020); send(24'h7f7f7f);
        drain();

        // R10: format tag follows the source bit when disabled and the destination bit when enabled
        base_cfg();
        s_en = 0; s_sy = 1; s_dy = 0;
        apply_cfg(); frame();
        cur_req = "R10";
        send(24'habcdef);
        drain();
        s_en = 1; s_sy = 0; s_dy = 1;
        s_k[0] = 512; s_k[4] = 512; s_k[8] = 512;
        apply_cfg(); frame();
        send(24'h010203);
        drain();

        // R9: random traffic against random backpressure on the BT.601 setting
        base_cfg();
        s_en = 1; s_sy = 1;
        s_k[0] = 596; s_k[2] = 817; s_k[3] = 596; s_k[4] = -200; s_k[5] = -416;
        s_k[6] = 596; s_k[7] = 1033;
        s_preb[0] = -16; s_preb[1] = -128; s_preb[2] = -128;
        s_postb[1] = 3; s_qlo[0] = 16; s_qhi[0] = 240;
        apply_cfg(); frame();
        cur_req = "R9";
        begin
            bit done = 0;
            fork
                begin
                    for (int i = 0; i < 300; i++) begin
                        if ($urandom % 4 == 0) idle();
                        send(24'($urandom));
                    end
                    idle();
                    done = 1;
                end
                begin
                    while (!done) begin
                        @(negedge clk); #1;
                        out_ready = ($urandom % 3) != 0;
                    end
                    @(negedge clk); #1;
                    out_ready = 1'b1;
                end
            join
        end
        drain();

        report("R9", 32'(expq.size()), 32'd0, expq.size() == 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule